// File: doc/BRIEF.md
# Failed-Word Replacement Store

This block sits next to a memory controller and stands in for up to 32 memory words that are known to be bad. Each of its 32 entries pairs an associative tag holding the physical word address of a failed location with a data word holding the good contents of that location. Every access address from the address mapper is compared against all live tags in the same cycle. When one matches, a read is served from the store's data word in place of main memory, and a write lands in the store's data word. The hit, the replacement data and a write-bypass flag are combinational from the access inputs, so a repaired access takes exactly as long as an ordinary one.

Entries are filled from a capture strobe raised by the error-correction logic when it has corrected a single-bit error. The strobe carries the failed address and the corrected word. If that address is already held, only the data word is refreshed. Otherwise the lowest-numbered free entry is taken. Once all 32 entries are live, the store reports itself full and further captures of new addresses are dropped. Bit 0 of each tag word is its live flag, and the address occupies the bits above it. Only a reset clears the live flags. A count output tells the rest of the controller how many entries are in use.

Top module: `heal_store`

## Requirements
- R1: After a synchronous active-low reset, no entry is live: `used_cnt` is 0, `store_full` is 0, `cap_dropped` is 0, and no access address produces a hit.
- R2: With `acc_valid` high and `acc_addr` equal to a live entry's address, `acc_hit` is 1 and `acc_rdata` equals that entry's data word in the same cycle, with no register on the path. On a miss, `acc_rdata` is all zeros.
- R3: An address that has not been captured since the last reset never produces a hit. An entry takes part in matching only while bit 0 of its tag word is set.
- R4: A capture (`cap_valid` high) of an address that no live entry holds, while the store is not full, makes that address hit from the next cycle with `cap_data` as its data, and raises `used_cnt` by one. The entry taken is the lowest-numbered free one.
- R5: A capture of an address that a live entry already holds replaces that entry's data word with `cap_data` and leaves `used_cnt` unchanged.
- R6: `store_full` is 1 exactly when all 32 entries are live. A capture of a new address while full is dropped: `used_cnt` is unchanged, the address still misses, and `cap_dropped` is 1 in the following cycle only.
- R7: An access with `acc_valid` and `acc_write` high that hits sets `wr_bypass` in that cycle, and the entry's data word becomes `acc_wdata` from the next cycle. A write that misses leaves `wr_bypass` at 0 and changes no entry.
- R8: At most one live entry matches any address, so repeated captures of one address never occupy more than one entry.
- R9: When a hitting access write and a capture of the same address occur in the same cycle, the access write data is what the entry holds afterwards.
- R10: With `acc_valid` low, `acc_hit` and `wr_bypass` are 0 whatever the address.
- R11: `used_cnt` always equals the number of live entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access address is valid this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Mapped physical word address of the access |
| acc_wdata | input | DATA_W | Write data of the access |
| acc_hit | output | 1 | Access address matches a live entry |
| acc_rdata | output | DATA_W | Replacement data on a hit, zero otherwise |
| wr_bypass | output | 1 | Hitting write: main-memory write may be suppressed |
| cap_valid | input | 1 | Capture strobe from the correction logic |
| cap_addr | input | ADDR_W | Address of the corrected failed word |
| cap_data | input | DATA_W | Corrected data word |
| store_full | output | 1 | All entries are live |
| cap_dropped | output | 1 | Previous cycle's capture was dropped because the store was full |
| used_cnt | output | CNT_W | Number of live entries (CNT_W = clog2(ENTRIES+1)) |

## Verification
The hardest states to reach are the full store and the same-cycle collision between a hitting write and a capture of the same address. Random traffic alone reaches neither reliably. The stimulus draws addresses from a pool of 48 so that hits, refreshes and allocations are all frequent and random captures push the store towards its limit. A directed sweep then captures the whole pool, which guarantees that all 32 entries are live before new captures are offered and dropped. The collision case is set up directly, with a write and a capture of one live address in the same cycle, followed by a read of that address.

// File: rtl/heal_pkg.sv
// Shared types for the failed-word replacement store.
// Assumes nothing beyond IEEE 1800-2017 packages.
package heal_pkg;

    // Action taken on a capture strobe in the current cycle.
    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_UPDATE = 2'd1,
        CAP_ALLOC  = 2'd2,
        CAP_DROP   = 2'd3
    } cap_act_e;

endpackage

// File: rtl/heal_match.sv
// Parallel tag comparator: compares one key against every tag and returns
// a hit vector with one bit per entry. Entries whose live flag is clear
// never hit. Assumes tags are packed entry 0 in the lowest bits.
module heal_match #(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 24
) (
    input  logic                        key_valid,
    input  logic [ADDR_W-1:0]           key,
    input  logic [ENTRIES*ADDR_W-1:0]   tag_flat,
    input  logic [ENTRIES-1:0]          live,
    output logic [ENTRIES-1:0]          hit_vec
);

    // One comparator per entry, all evaluated at once.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = key_valid && live[g] &&
                            (tag_flat[g*ADDR_W +: ADDR_W] == key);
    end

endmodule

// File: rtl/heal_first_free.sv
// Priority encoder over the live flags: finds the lowest-numbered free
// entry. found is low when every entry is live. Assumes ENTRIES >= 2.
module heal_first_free #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] live,
    output logic [IDX_W-1:0]   free_idx,
    output logic               found
);

    // Scan from the top down so the lowest free index is the last written.
    always_comb begin
        free_idx = '0;
        found    = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!live[i]) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/heal_popcount.sv
// Counts the set bits of a live-flag vector.
// Assumes CNT_W is wide enough to hold ENTRIES.
module heal_popcount #(
    parameter int ENTRIES = 32,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic [ENTRIES-1:0] live,
    output logic [CNT_W-1:0]   count
);

    // Add up one bit per entry.
    always_comb begin
        count = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            count = count + CNT_W'(live[i]);
        end
    end

endmodule

// File: rtl/heal_store.sv
// Failed-word replacement store. Holds ENTRIES tag/data pairs. Each tag
// word carries the failed address above a live flag in bit 0. Access
// lookups are purely combinational, so a hit adds no cycle. Captures
// refresh a matching entry or fill the lowest free one. Assumes the
// caller uses wr_bypass to suppress the main-memory write and that
// each capture address comes from a real corrected error.
module heal_store
    import heal_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_hit,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              wr_bypass,
    input  logic              cap_valid,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    output logic              store_full,
    output logic              cap_dropped,
    output logic [CNT_W-1:0]  used_cnt
);

    // Tag words: [ADDR_W:1] address, [0] live flag.
    logic [ADDR_W:0]            tag_word [ENTRIES];
    logic [DATA_W-1:0]          data_word [ENTRIES];
    logic [ENTRIES*ADDR_W-1:0]  tag_flat;
    logic [ENTRIES-1:0]         live;
    logic [ENTRIES-1:0]         acc_vec;
    logic [ENTRIES-1:0]         cap_vec;
    logic [IDX_W-1:0]           free_idx;
    logic                       free_found;
    cap_act_e                   cap_act;

    // Flatten tag words into address bus and live-flag vector for the comparators.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tag_flat[i*ADDR_W +: ADDR_W] = tag_word[i][ADDR_W:1];
            live[i]                      = tag_word[i][0];
        end
    end

    heal_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_acc_match (
        .key_valid (acc_valid),
        .key       (acc_addr),
        .tag_flat  (tag_flat),
        .live      (live),
        .hit_vec   (acc_vec)
    );

    heal_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cap_match (
        .key_valid (cap_valid),
        .key       (cap_addr),
        .tag_flat  (tag_flat),
        .live      (live),
        .hit_vec   (cap_vec)
    );

    heal_first_free #(.ENTRIES(ENTRIES)) u_free (
        .live     (live),
        .free_idx (free_idx),
        .found    (free_found)
    );

    heal_popcount #(.ENTRIES(ENTRIES)) u_count (
        .live  (live),
        .count (used_cnt)
    );

    // Combinational read path: OR together the data of the (single) hitting entry.
    always_comb begin
        acc_rdata = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (acc_vec[i]) begin
                acc_rdata = acc_rdata | data_word[i];
            end
        end
    end

    assign acc_hit    = |acc_vec;
    assign wr_bypass  = acc_hit && acc_write;
    assign store_full = !free_found;

    // Decide what a capture strobe does this cycle.
    always_comb begin
        if (!cap_valid) begin
            cap_act = CAP_IDLE;
        end else if (|cap_vec) begin
            cap_act = CAP_UPDATE;
        end else if (free_found) begin
            cap_act = CAP_ALLOC;
        end else begin
            cap_act = CAP_DROP;
        end
    end

    // Tag words: reset clears live flags, allocation writes address and sets live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_word[i][0] <= 1'b0;
            end
        end else if (cap_act == CAP_ALLOC) begin
            tag_word[free_idx] <= {cap_addr, 1'b1};
        end
    end

    // Data words: capture writes first, a hitting access write overrides it.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if ((cap_act == CAP_ALLOC && free_idx == IDX_W'(i)) ||
                (cap_act == CAP_UPDATE && cap_vec[i])) begin
                data_word[i] <= cap_data;
            end
            if (acc_write && acc_vec[i]) begin
                data_word[i] <= acc_wdata;
            end
        end
    end

    // One-cycle pulse reporting a capture dropped while full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_dropped <= 1'b0;
        end else begin
            cap_dropped <= (cap_act == CAP_DROP);
        end
    end

    // R8: tag uniqueness keeps every lookup at most one hot.
    assert_one_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_vec) && $onehot0(cap_vec));

    // R6 / R11: the full flag and the population count agree.
    assert_full_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        store_full == (used_cnt == CNT_W'(ENTRIES)));

    // R4: an allocation adds exactly one live entry.
    assert_alloc_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_act == CAP_ALLOC) |=> (used_cnt == $past(used_cnt) + 1'b1));

    // R5: refreshing an existing entry leaves the count alone.
    assert_update_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_act == CAP_UPDATE) |=> $stable(used_cnt));

    // R6: a dropped capture changes nothing and is reported next cycle.
    assert_drop_reported_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_act == CAP_DROP) |=> ($stable(used_cnt) && cap_dropped));

    // R10: no hit or bypass without a valid access.
    assert_hit_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit || wr_bypass) |-> acc_valid);

endmodule

// File: tb/heal_store_tb.sv
module heal_store_tb;

    localparam int ENT = 32;
    localparam int AW  = 24;
    localparam int DW  = 32;
    localparam int CW  = $clog2(ENT + 1);
    localparam int POOL = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic          acc_hit, wr_bypass;
    logic [DW-1:0] acc_rdata;
    logic          cap_valid = 1'b0;
    logic [AW-1:0] cap_addr = '0;
    logic [DW-1:0] cap_data = '0;
    logic          store_full, cap_dropped;
    logic [CW-1:0] used_cnt;

    int checks = 0;
    int errors = 0;

    // Reference model
    logic [AW-1:0] ref_addr [ENT];
    logic [DW-1:0] ref_data [ENT];
    logic          ref_live [ENT];
    logic          exp_drop = 1'b0;

    always #4 clk = ~clk;

    heal_store #(.ENTRIES(ENT), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_wdata,
        .acc_hit, .acc_rdata, .wr_bypass, .cap_valid, .cap_addr, .cap_data,
        .store_full, .cap_dropped, .used_cnt
    );

    function automatic logic [AW-1:0] pool_addr(int k);
        return AW'(24'h000100 + k * 3);
    endfunction

    function automatic int ref_find(logic [AW-1:0] a);
        for (int i = 0; i < ENT; i++) if (ref_live[i] && ref_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int ref_free();
        for (int i = 0; i < ENT; i++) if (!ref_live[i]) return i;
        return -1;
    endfunction

    function automatic int ref_count();
        int n = 0;
        for (int i = 0; i < ENT; i++) if (ref_live[i]) n++;
        return n;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock of stimulus: drive at negedge, check combinational outputs, advance.
    task automatic step(logic v, logic w, logic [AW-1:0] a, logic [DW-1:0] wd,
                        logic cv, logic [AW-1:0] ca, logic [DW-1:0] cd);
        int mi, cm, ff;
        logic eh;
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = wd;
        cap_valid = cv; cap_addr = ca; cap_data = cd;
        #1;
        mi = ref_find(a);
        eh = v && (mi >= 0);
        check("R3 hit", acc_hit, eh);
        check("R2 rdata", acc_rdata, eh ? ref_data[mi] : '0);
        check("R7 bypass", wr_bypass, eh && w);
        check("R11 count", used_cnt, ref_count());
        check("R6 full", store_full, ref_count() == ENT);
        check("R6 dropped", cap_dropped, exp_drop);
        exp_drop = 1'b0;
        if (cv) begin
            cm = ref_find(ca);
            ff = ref_free();
            if (cm >= 0) ref_data[cm] = cd;
            else if (ff >= 0) begin
                ref_live[ff] = 1'b1; ref_addr[ff] = ca; ref_data[ff] = cd;
            end else exp_drop = 1'b1;
        end
        if (eh && w) ref_data[mi] = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive a read without a clock edge and settle.
    task automatic probe(logic v, logic [AW-1:0] a);
        acc_valid = v; acc_write = 1'b0; acc_addr = a; cap_valid = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        acc_valid = 1'b0; acc_write = 1'b0; cap_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < ENT; i++) ref_live[i] = 1'b0;
        exp_drop = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] a_x, a_y;
        void'($urandom(32'd7531));
        for (int i = 0; i < ENT; i++) begin
            ref_live[i] = 1'b0; ref_addr[i] = '0; ref_data[i] = '0;
        end
        @(negedge clk);
        do_reset();

        // R1: reset state
        probe(1'b1, pool_addr(0));
        check("R1 count", used_cnt, 0);
        check("R1 full", store_full, 0);
        check("R1 dropped", cap_dropped, 0);
        check("R1 hit", acc_hit, 0);

        a_x = pool_addr(5);
        a_y = pool_addr(6);
        // R3: miss before capture; R4: capture then hit
        step(1, 0, a_x, '0, 1, a_x, 32'h1111_0001);
        probe(1'b1, a_x);
        check("R4 hit after capture", acc_hit, 1);
        check("R4 data after capture", acc_rdata, 32'h1111_0001);
        check("R4 count", used_cnt, 1);
        // R5 / R8: recapture same address refreshes data, count unchanged
        step(0, 0, a_x, '0, 1, a_x, 32'h2222_0002);
        step(0, 0, a_x, '0, 1, a_x, 32'h3333_0003);
        probe(1'b1, a_x);
        check("R5 data refreshed", acc_rdata, 32'h3333_0003);
        check("R8 single entry", used_cnt, 1);
        // R7: write hit and write miss
        step(1, 1, a_x, 32'hABCD_0007, 0, '0, '0);
        step(1, 1, a_y, 32'hDEAD_0008, 0, '0, '0);
        probe(1'b1, a_x);
        check("R7 write updates entry", acc_rdata, 32'hABCD_0007);
        probe(1'b1, a_y);
        check("R7 write miss no hit", acc_hit, 0);
        // R9: collision of write and capture on same address
        step(1, 1, a_x, 32'h9999_0009, 1, a_x, 32'h4444_0004);
        probe(1'b1, a_x);
        check("R9 access write wins", acc_rdata, 32'h9999_0009);
        // R10: invalid access never hits
        probe(1'b0, a_x);
        check("R10 no hit when invalid", acc_hit, 0);
        step(0, 1, a_x, 32'h5555_0005, 0, '0, '0);
        probe(1'b1, a_x);
        check("R10 invalid write ignored", acc_rdata, 32'h9999_0009);

        // Random traffic over a 48-address pool
        for (int n = 0; n < 2000; n++) begin
            step(($urandom % 4) != 0, $urandom % 2, pool_addr($urandom % POOL), $urandom,
                 ($urandom % 6) == 0, pool_addr($urandom % POOL), $urandom);
        end

        // Directed fill to full, then dropped captures (R6)
        for (int k = 0; k < POOL; k++) step(0, 0, '0, '0, 1, pool_addr(k), 32'h7000_0000 + k);
        check("R6 full after fill", store_full, 1);
        check("R11 count at full", used_cnt, ENT);
        step(1, 0, 24'hFFFFF0, '0, 1, 24'hFFFFF0, 32'h0BAD_0BAD);
        check("R6 drop pulse", cap_dropped, 1);
        probe(1'b1, 24'hFFFFF0);
        check("R6 dropped address misses", acc_hit, 0);
        check("R6 count unchanged", used_cnt, ENT);
        step(0, 0, '0, '0, 0, '0, '0);
        check("R6 drop pulse one cycle", cap_dropped, 0);

        // R1: reset again clears everything
        do_reset();
        probe(1'b1, pool_addr(0));
        check("R1 hit after reset", acc_hit, 0);
        check("R1 count after reset", used_cnt, 0);
        check("R1 full after reset", store_full, 0);
        for (int n = 0; n < 300; n++) begin
            step(1, $urandom % 2, pool_addr($urandom % POOL), $urandom,
                 ($urandom % 3) == 0, pool_addr($urandom % POOL), $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule